// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block turns an asynchronous serial line into characters. It works from a 16x oversampling enable that an external rate generator supplies. It finds each start bit and confirms it at the middle of the bit. It then samples every data, parity and stop bit at the centre of its cell. The result is placed in a one-byte receive holding register.

Character size (5 to 8 data bits) and parity (none, even or odd) come from static configuration inputs. Status outputs report four conditions: holding register full, overrun, parity error and framing error. An interrupt request is raised only when the receive interrupt enable is set. A one-cycle read strobe marks that the host has taken the character, and it clears the full flag and all three error flags. Two modem inputs, data-set-ready and carrier-detect, are copied straight onto status outputs.

Top module: `async_rx_unit`

## Requirements
- R1: After reset, `rx_data` is 0 and `stat_full`, `stat_ovr`, `stat_par`, `stat_frm` and `irq` are all 0.
- R2: A low level on the synchronized line, seen while idle, opens a frame. The line is looked at again 8 ticks later. If it is high by then, the event is dropped and no character is produced.
- R3: `cfg_len` gives the character size as 5 + `cfg_len` data bits (0 means 5, 3 means 8). Data bits are sampled at the middle of each 16-tick cell and arrive least significant first. Bits above the character size read back as 0 in `rx_data`.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` = 0 the data bits and parity bit together must hold an even number of ones; with `cfg_par_odd` = 1 they must hold an odd number. A mismatch sets `stat_par`. When `cfg_par_en` is 0, no parity bit is expected and `stat_par` stays 0.
- R5: If the middle of the first stop bit samples low, `stat_frm` is set together with the character.
- R6: A completed character is written to `rx_data` and sets `stat_full`.
- R7: If a character completes while `stat_full` is 1, `stat_ovr` is set. The previous `rx_data` is kept and the new character is discarded.
- R8: A one-cycle pulse on `rd_strobe` clears `stat_full`, `stat_ovr`, `stat_par` and `stat_frm` on the next clock. If a character completes in the same cycle, it is stored as a fresh character and no overrun is recorded.
- R9: `irq` is 1 exactly when `stat_full` is 1 and `rx_irq_en` is 1.
- R10: `stat_dsr` follows `dsr_in` and `stat_dcd` follows `dcd_in`, with no delay.
- R11: After a frame, a new start bit is accepted only once the line has been sampled high. A line held low after a framing error produces no further characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Character size code, data bits = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Host has read the character; clears flags |
| dsr_in | input | 1 | Data-set-ready level |
| dcd_in | input | 1 | Carrier-detect level |
| rx_data | output | 8 | Receive holding register |
| stat_full | output | 1 | Holding register full |
| stat_ovr | output | 1 | Overrun |
| stat_par | output | 1 | Parity error |
| stat_frm | output | 1 | Framing error |
| stat_dsr | output | 1 | Copy of dsr_in |
| stat_dcd | output | 1 | Copy of dcd_in |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by the assertions on every cycle. Overrun and the error flags never appear without a full register. The held character does not change while the register is full and unread. A parity error persists until read. A read always removes any overrun.

Other behaviour depends on whole frames, so only the bench scenarios can show it. This covers correct bit order and zero fill for each character size, the parity decision, noise rejection at mid-start, the rule that a held-low line must return high, and interrupt gating.

// File: rtl/async_rx_pkg.sv
// Package: shared constants and types for the asynchronous receiver.
// Assumes a fixed 8-bit holding register and a 16x oversampling enable.
package async_rx_pkg;
    localparam int DATA_W  = 8;
    localparam int OSR     = 16;
    localparam int CNT_W   = $clog2(OSR);
    localparam int MID     = OSR / 2 - 1;
    localparam int MIN_LEN = 5;
    localparam int IDX_W   = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;
endpackage

// File: rtl/rx_line_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizing flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
// Module: frame sequencer. It validates the start bit, samples data, parity and
// stop bits at mid-cell, and emits a one-cycle done pulse with the
// aligned character and its error bits.
// Assumes rx_s is already synchronized and tick arrives OSR times per bit.
module rx_frame_fsm
    import async_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       done,
    output rx_char_t   char_o
);
    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              armed;

    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  shamt;
    logic [DATA_W-1:0] aligned;
    logic              ones_odd;
    logic              cell_end;

    // Derive the last data index, the alignment shift and the parity result.
    always_comb begin
        last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_len);
        shamt    = IDX_W'(DATA_W - MIN_LEN) - IDX_W'(cfg_len);
        aligned  = shreg >> shamt;
        ones_odd = (^aligned) ^ par_bit;
        cell_end = (cnt == CNT_W'(OSR - 1));
    end

    // Step the frame state machine on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            armed   <= 1'b0;
            done    <= 1'b0;
            char_o  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (rx_s) begin
                            armed <= 1'b1;
                        end else if (armed) begin
                            armed <= 1'b0;
                            cnt   <= '0;
                            state <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_W'(MID)) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            if (rx_s) begin
                                armed <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_DATA;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (cell_end) begin
                            shreg <= {rx_s, shreg[DATA_W-1:1]};
                            if (bit_idx == last_idx)
                                state <= cfg_par_en ? ST_PAR : ST_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (cell_end) begin
                            par_bit <= rx_s;
                            state   <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (cell_end) begin
                            done           <= 1'b1;
                            char_o.data    <= aligned;
                            char_o.frm_err <= ~rx_s;
                            char_o.par_err <= cfg_par_en &
                                              (cfg_par_odd ? ~ones_odd : ones_odd);
                            par_bit        <= 1'b0;
                            armed          <= rx_s;
                            state          <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_hold_reg.sv
// Module: one-byte receive holding register with full, overrun,
// parity and framing flags.
// Assumes done and rd are single-cycle pulses. When both occur together,
// the new character replaces the one being read.
module rx_hold_reg
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  rx_char_t          char_i,
    input  logic              rd,
    output logic [DATA_W-1:0] data_q,
    output logic              full_q,
    output logic              ovr_q,
    output logic              par_q,
    output logic              frm_q
);
    logic room;

    // Space is available when the register is empty or is being read now.
    always_comb room = ~full_q | rd;

    // Update the holding register and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
        end else if (done && room) begin
            data_q <= char_i.data;
            full_q <= 1'b1;
            ovr_q  <= 1'b0;
            par_q  <= char_i.par_err;
            frm_q  <= char_i.frm_err;
        end else if (done) begin
            ovr_q  <= 1'b1;
        end else if (rd) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/async_rx_unit.sv
// Module: top of the asynchronous receiver. It joins the synchronizer,
// the frame sequencer and the holding register, gates the interrupt
// and passes the modem levels through.
// Assumes tick16 is a one-cycle enable at 16x the bit rate.
module async_rx_unit
    import async_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rx_irq_en,
    input  logic       rd_strobe,
    input  logic       dsr_in,
    input  logic       dcd_in,
    output logic [7:0] rx_data,
    output logic       stat_full,
    output logic       stat_ovr,
    output logic       stat_par,
    output logic       stat_frm,
    output logic       stat_dsr,
    output logic       stat_dcd,
    output logic       irq
);
    logic     rx_s;
    logic     done;
    rx_char_t char_w;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    rx_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .rx_s       (rx_s),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .done       (done),
        .char_o     (char_w)
    );

    rx_hold_reg u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .char_i(char_w),
        .rd    (rd_strobe),
        .data_q(rx_data),
        .full_q(stat_full),
        .ovr_q (stat_ovr),
        .par_q (stat_par),
        .frm_q (stat_frm)
    );

    // Gate the interrupt and copy the modem levels to status.
    always_comb begin
        irq      = stat_full & rx_irq_en;
        stat_dsr = dsr_in;
        stat_dcd = dcd_in;
    end
endmodule

// File: rtl/async_rx_unit_chk.sv
// Module: assertion checker for async_rx_unit, attached by bind.
// Assumes rd_strobe is driven only as a single-cycle pulse.
module async_rx_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic [7:0] rx_data,
    input logic       stat_full,
    input logic       stat_ovr,
    input logic       stat_par,
    input logic       stat_frm
);
    assert_ovr_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ovr |-> stat_full);

    assert_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_full && !rd_strobe) |=> $stable(rx_data));

    assert_read_clears_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !stat_ovr);

    assert_frm_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_frm |-> stat_full);

    assert_par_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_par && !rd_strobe) |=> stat_par);
endmodule

bind async_rx_unit async_rx_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_strobe(rd_strobe),
    .rx_data  (rx_data),
    .stat_full(stat_full),
    .stat_ovr (stat_ovr),
    .stat_par (stat_par),
    .stat_frm (stat_frm)
);

// File: tb/async_rx_unit_test.sv
// Bench: drives serial frames at 16 ticks per bit (one tick every two clocks)
// and compares the status outputs with values computed from the requirements.
module async_rx_unit_test;
    localparam int BIT_CLK = 32;
    localparam int WDOG    = 100000;

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic [7:0] data;
        logic       badp;
        logic       bads;
        logic [7:0] exp_data;
        logic       exp_pe;
        logic       exp_fe;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b0, 8'h2D, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0},
        '{2'd2, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
        '{2'd3, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b1, 8'h0A, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rx_irq_en = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       dsr_in = 1'b0;
    logic       dcd_in = 1'b0;
    logic [7:0] rx_data;
    logic       stat_full, stat_ovr, stat_par, stat_frm;
    logic       stat_dsr, stat_dcd, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    async_rx_unit uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rx_irq_en(rx_irq_en), .rd_strobe(rd_strobe),
        .dsr_in(dsr_in), .dcd_in(dcd_in),
        .rx_data(rx_data), .stat_full(stat_full), .stat_ovr(stat_ovr),
        .stat_par(stat_par), .stat_frm(stat_frm),
        .stat_dsr(stat_dsr), .stat_dcd(stat_dcd), .irq(irq)
    );

    always #2 clk = ~clk;

    // Oversampling enable on every other clock.
    always @(negedge clk) tick16 <= ~tick16;

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // Send one frame; bads forces a low stop bit, badp inverts parity.
    task automatic send(input logic [1:0] len, input logic pen, input logic podd,
                        input logic [7:0] d, input logic badp, input logic bads);
        int n;
        logic [7:0] m;
        logic pb;
        n  = 5 + int'(len);
        m  = d & 8'((1 << n) - 1);
        pb = (podd ? ~(^m) : (^m)) ^ badp;
        cfg_len = len; cfg_par_en = pen; cfg_par_odd = podd;
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) hold_bit(d[i]);
        if (pen) hold_bit(pb);
        hold_bit(~bads);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic read_pulse();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 data", rx_data, 8'h00);
        chk("R1 flags", {stat_full, stat_ovr, stat_par, stat_frm, irq}, 5'b0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 after release", {stat_full, stat_ovr, stat_par, stat_frm, irq}, 5'b0);

        // Table walk: R3 length/order/zero fill, R4 parity, R5 framing, R6, R8, R9
        for (int v = 0; v < NV; v++) begin
            send(VECS[v].len, VECS[v].pen, VECS[v].podd, VECS[v].data,
                 VECS[v].badp, VECS[v].bads);
            chk("R3 data", rx_data, VECS[v].exp_data);
            chk("R6 full", stat_full, 1'b1);
            chk("R4 parity flag", stat_par, VECS[v].exp_pe);
            chk("R5 framing flag", stat_frm, VECS[v].exp_fe);
            chk("R9 irq enabled", irq, 1'b1);
            read_pulse();
            chk("R8 cleared", {stat_full, stat_ovr, stat_par, stat_frm}, 4'b0);
        end

        // R2: short low glitch rejected at mid-start
        rx_in = 1'b0;
        repeat (8) @(negedge clk);
        rx_in = 1'b1;
        repeat (16 * BIT_CLK) @(negedge clk);
        chk("R2 glitch rejected", stat_full, 1'b0);
        send(2'd3, 1'b0, 1'b0, 8'h6E, 1'b0, 1'b0);
        chk("R2 frame after glitch", rx_data, 8'h6E);
        read_pulse();

        // R7: overrun keeps the first character
        send(2'd3, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
        send(2'd3, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
        chk("R7 overrun flag", stat_ovr, 1'b1);
        chk("R7 old data kept", rx_data, 8'h11);
        read_pulse();
        chk("R8 overrun cleared", {stat_full, stat_ovr}, 2'b0);

        // R9: interrupt gated by enable
        rx_irq_en = 1'b0;
        send(2'd3, 1'b0, 1'b0, 8'h42, 1'b0, 1'b0);
        chk("R9 full while gated", stat_full, 1'b1);
        chk("R9 irq gated off", irq, 1'b0);
        rx_irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq on enable", irq, 1'b1);
        read_pulse();
        chk("R9 irq after read", irq, 1'b0);

        // R11: line held low after a framing error yields one character only
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(1'b0);
        hold_bit(1'b0);
        chk("R11 break frame flagged", {stat_full, stat_frm}, 2'b11);
        read_pulse();
        for (int i = 0; i < 20; i++) hold_bit(1'b0);
        chk("R11 no retrigger while low", stat_full, 1'b0);
        hold_bit(1'b1);
        send(2'd3, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0);
        chk("R11 frame after line high", rx_data, 8'h99);
        read_pulse();

        // R10: modem levels pass through
        dsr_in = 1'b1; dcd_in = 1'b0;
        @(negedge clk);
        chk("R10 dsr/dcd 10", {stat_dsr, stat_dcd}, 2'b10);
        dsr_in = 1'b0; dcd_in = 1'b1;
        @(negedge clk);
        chk("R10 dsr/dcd 01", {stat_dsr, stat_dcd}, 2'b01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule